// File: doc/BRIEF.md
# Serial Board-Link Transaction Controller

This block runs one request/response exchange at a time with a remote front-end board over a half-duplex, byte-serial line. A pulse on `start` makes it send a fixed-length request frame. The frame opens with a delimiter byte, carries the caller's payload, and closes with a CRC-8 over everything before it. The block then releases the line and listens for a reply frame of the same length. It checks the reply's delimiter and CRC and returns the reply payload on a parallel bus.

An attempt fails when no complete reply arrives in time, or when the reply is malformed. After a failed attempt the block sends the same request again, up to a fixed number of extra tries. The outcome is reported by a one-cycle `done` pulse together with an error flag and a cause code. With the default parameters, a 50 MHz clock gives 250 kbit/s, 28-byte frames, a 2 ms reply window and two retries. The retry count must stay below 3.

Top module: `slink_ctrl`

## Requirements
- R1: Each byte on `tx_o` is one low start bit, eight data bits least significant first, and one high stop bit, each bit lasting CLKS_PER_BIT clocks (200 by default).
- R2: A request frame is FRAME_BYTES bytes (28 by default). Byte 0 is 0x40. Byte k for k = 1..26 is `req_payload[8(k-1)+7 : 8(k-1)]`. Byte 27 is the CRC.
- R3: The CRC is CRC-8 with polynomial 0x07 and start value 0xFF. It is computed most significant bit first with no final inversion, over bytes 0..26, with each byte XORed into the register before eight shift steps.
- R4: `de_o` is high while a request frame is being sent and low otherwise. `tx_o` is high whenever `de_o` is low.
- R5: A reply is accepted when 28 bytes arrive on `rx_i`, byte 0 is 0x40 and byte 27 equals the CRC of bytes 0..26. On acceptance, `done` pulses with `err`=0 and `err_code`=0, and `rsp_payload` holds reply bytes 1..26 in the same byte order as R2.
- R6: If the last byte of a complete reply has not arrived within TIMEOUT_CLKS clocks (100000 by default) after the request frame ends, the attempt fails with cause timeout.
- R7: A complete reply with a wrong delimiter or a wrong CRC makes the attempt fail with cause bad frame.
- R8: After a failed attempt the request is sent again at once, up to MAX_RETRY extra times (2 by default), and never more than that.
- R9: When the final attempt fails, `done` pulses with `err`=1 and `err_code` set to 1 for timeout or 2 for bad frame, according to the cause of that last attempt.
- R10: The receiver ignores `rx_i` while the block is sending, so an echo of its own request is never taken as a reply.
- R11: `done` lasts exactly one clock. After reset, `done`=0, `de_o`=0 and `tx_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (taken only when idle) |
| req_payload | input | (FRAME_BYTES-2)*8 | Request payload, byte 1 in the low bits |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| err | output | 1 | Exchange failed, valid with `done` |
| err_code | output | 2 | 0 ok, 1 timeout, 2 bad frame, valid with `done` |
| rsp_payload | output | (FRAME_BYTES-2)*8 | Reply payload, valid when `done` is high and `err` is low |
| tx_o | output | 1 | Serial transmit line |
| de_o | output | 1 | Line driver enable |
| rx_i | input | 1 | Serial receive line |

## Verification
The properties assume that `start` is pulsed only while the block is idle. They also assume that `rx_i` rests high except during a remote reply, and that a remote reply starts only after the request's last stop bit. The stimulus waits for each `done` before the next `start`. It begins every reply two bit times after the last request stop bit it decoded, and it drives the last reply stop bit high and leaves the line there. In the echo scenario, `rx_i` carries a copy of `tx_o`; this is the only case where the receive line moves during transmission.

// File: rtl/slink_pkg.sv
package slink_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } slink_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_TIMEOUT = 2'd1,
    CAUSE_BADFRM  = 2'd2
  } slink_cause_e;

  // One byte of CRC-8, MSB first, byte folded in before the shifts.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/slink_tx.sv
module slink_tx #(
  parameter int CLKS_PER_BIT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data_i,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] C_LAST = CW'(CLKS_PER_BIT - 1);

  logic [9:0]    sh_q, sh_d;
  logic [3:0]    bit_q, bit_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (load) begin
        sh_d   = {1'b1, data_i, 1'b0};
        busy_d = 1'b1;
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (cnt_q == C_LAST) begin
      cnt_d = '0;
      if (bit_q == 4'd9) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[9:1]};
        bit_d = bit_q + 4'd1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
  assign busy_o = busy_q;
endmodule

// File: rtl/slink_rx.sv
module slink_rx #(
  parameter int CLKS_PER_BIT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] C_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] C_HALF = CW'(CLKS_PER_BIT / 2);

  logic          s1_q, s2_q;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          valid_q, valid_d;

  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (!en_i) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (!s2_q) begin
        act_d = 1'b1;
        cnt_d = C_HALF;
        bit_d = '0;
      end
    end else if (cnt_q == C_LAST) begin
      cnt_d = '0;
      bit_d = bit_q + 4'd1;
      if (bit_q == 4'd0) begin
        if (s2_q) act_d = 1'b0;
      end else if (bit_q == 4'd9) begin
        act_d   = 1'b0;
        valid_d = 1'b1;
      end else begin
        sh_d = {s2_q, sh_q[7:1]};
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      s1_q    <= rx_i;
      s2_q    <= s1_q;
      act_q   <= act_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/slink_ctrl.sv
module slink_ctrl
  import slink_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 200,
  parameter int         FRAME_BYTES  = 28,
  parameter int         TIMEOUT_CLKS = 100000,
  parameter int         MAX_RETRY    = 2,
  parameter logic [7:0] DELIM        = 8'h40,
  parameter logic [7:0] CRC_POLY     = 8'h07,
  parameter logic [7:0] CRC_INIT     = 8'hFF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [(FRAME_BYTES-2)*8-1:0] req_payload,
  output logic                         done,
  output logic                         err,
  output logic [1:0]                   err_code,
  output logic [(FRAME_BYTES-2)*8-1:0] rsp_payload,
  output logic                         tx_o,
  output logic                         de_o,
  input  logic                         rx_i
);
  localparam int PAY_BYTES = FRAME_BYTES - 2;
  localparam int IDXW      = $clog2(FRAME_BYTES + 1);
  localparam int TMOW      = $clog2(TIMEOUT_CLKS);
  localparam int ATW       = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_BYTES - 1);
  localparam logic [IDXW-1:0] END_IDX  = IDXW'(FRAME_BYTES);
  localparam logic [TMOW-1:0] TMO_LAST = TMOW'(TIMEOUT_CLKS - 1);
  localparam logic [ATW-1:0]  ATT_LAST = ATW'(MAX_RETRY);

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_i      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_i      <= rst_meta_q;
    end
  end

  slink_state_e    state_q, state_d;
  logic [ATW-1:0]  att_q, att_d;
  logic [IDXW-1:0] idx_q, idx_d;      // next request byte to load
  logic [IDXW-1:0] ridx_q, ridx_d;    // next reply byte expected
  logic [7:0]      crc_q, crc_d;      // shared by send and receive
  logic [TMOW-1:0] tmo_q, tmo_d;
  logic            dok_q, dok_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  slink_cause_e    code_q, code_d;
  logic            rsp_we;
  logic            fail;
  slink_cause_e    fail_code;

  logic            tx_load, tx_busy;
  logic [7:0]      tx_byte;
  logic            rx_valid;
  logic [7:0]      rx_byte;
  logic [7:0]      req_arr [PAY_BYTES];
  logic [7:0]      rsp_q   [PAY_BYTES];
  logic [IDXW-1:0] idx_m1, ridx_m1;

  assign idx_m1  = idx_q - 1'b1;
  assign ridx_m1 = ridx_q - 1'b1;

  for (genvar g = 0; g < PAY_BYTES; g++) begin : g_bytes
    assign req_arr[g] = req_payload[g*8 +: 8];
    assign rsp_payload[g*8 +: 8] = rsp_q[g];
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i)                                rsp_q[g] <= '0;
      else if (rsp_we && ridx_m1 == IDXW'(g))    rsp_q[g] <= rx_byte;
    end
  end

  always_comb begin
    if (idx_q == '0)           tx_byte = DELIM;
    else if (idx_q == LAST_IDX) tx_byte = crc_q;
    else                        tx_byte = req_arr[idx_m1];
  end

  always_comb begin
    state_d   = state_q;
    att_d     = att_q;
    idx_d     = idx_q;
    ridx_d    = ridx_q;
    crc_d     = crc_q;
    tmo_d     = tmo_q;
    dok_d     = dok_q;
    done_d    = 1'b0;
    err_d     = err_q;
    code_d    = code_q;
    rsp_we    = 1'b0;
    tx_load   = 1'b0;
    fail      = 1'b0;
    fail_code = CAUSE_NONE;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          att_d   = '0;
          idx_d   = '0;
          crc_d   = CRC_INIT;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (!tx_busy) begin
          if (idx_q != END_IDX) begin
            tx_load = 1'b1;
            idx_d   = idx_q + 1'b1;
            if (idx_q != LAST_IDX) crc_d = crc8_step(crc_q, tx_byte, CRC_POLY);
          end else begin
            state_d = ST_WAIT;
            tmo_d   = '0;
            ridx_d  = '0;
            crc_d   = CRC_INIT;
          end
        end
      end
      ST_WAIT: begin
        tmo_d = tmo_q + 1'b1;
        if (rx_valid) begin
          ridx_d = ridx_q + 1'b1;
          if (ridx_q == '0) dok_d = (rx_byte == DELIM);
          if (ridx_q != LAST_IDX) crc_d = crc8_step(crc_q, rx_byte, CRC_POLY);
          rsp_we = (ridx_q != '0) && (ridx_q != LAST_IDX);
          if (ridx_q == LAST_IDX) begin
            if (dok_q && rx_byte == crc_q) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              err_d   = 1'b0;
              code_d  = CAUSE_NONE;
            end else begin
              fail      = 1'b1;
              fail_code = CAUSE_BADFRM;
            end
          end
        end else if (tmo_q == TMO_LAST) begin
          fail      = 1'b1;
          fail_code = CAUSE_TIMEOUT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fail) begin
      if (att_q == ATT_LAST) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        err_d   = 1'b1;
        code_d  = fail_code;
      end else begin
        att_d   = att_q + 1'b1;
        idx_d   = '0;
        crc_d   = CRC_INIT;
        state_d = ST_SEND;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      att_q   <= '0;
      idx_q   <= '0;
      ridx_q  <= '0;
      crc_q   <= '0;
      tmo_q   <= '0;
      dok_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      att_q   <= att_d;
      idx_q   <= idx_d;
      ridx_q  <= ridx_d;
      crc_q   <= crc_d;
      tmo_q   <= tmo_d;
      dok_q   <= dok_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end

  slink_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
    .clk(clk), .rst_n(rst_i), .load(tx_load), .data_i(tx_byte),
    .tx_o(tx_o), .busy_o(tx_busy)
  );

  slink_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_u (
    .clk(clk), .rst_n(rst_i), .en_i(state_q == ST_WAIT), .rx_i(rx_i),
    .valid_o(rx_valid), .data_o(rx_byte)
  );

  assign de_o     = (state_q == ST_SEND);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;
endmodule

// File: rtl/slink_ctrl_chk.sv
module slink_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       tx_o,
  input logic       de_o
);
  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> tx_o);

  assert_start_bit_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_o) |-> de_o);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ok_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (err_code == 2'd0));

  assert_fail_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (err_code == 2'd1 || err_code == 2'd2));

  assert_line_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !de_o);
endmodule

bind slink_ctrl slink_ctrl_chk chk_i (.*);

// File: tb/slink_ctrl_tb_top.sv
module slink_ctrl_tb_top;
  localparam int CPB = 8;
  localparam int FB  = 28;
  localparam int PB  = FB - 2;
  localparam int TMO = 4000;
  localparam int P_GOOD = 0, P_NONE = 1, P_BADCRC = 2, P_BADDELIM = 3;

  typedef logic [7:0] frame_t [FB];

  logic clk;
  logic rst_n, start, done, err, tx_o, de_o, rx_i, rx_drv, echo;
  logic [1:0] err_code;
  logic [PB*8-1:0] req, rsp;
  int n_checks, n_err, done_cnt;
  logic cap_err;
  logic [1:0] cap_code;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign rx_i = echo ? tx_o : rx_drv;

  slink_ctrl #(.CLKS_PER_BIT(CPB), .FRAME_BYTES(FB), .TIMEOUT_CLKS(TMO), .MAX_RETRY(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_payload(req), .done(done), .err(err),
    .err_code(err_code), .rsp_payload(rsp), .tx_o(tx_o), .de_o(de_o), .rx_i(rx_i)
  );

  always @(negedge clk) if (done) begin
    done_cnt++;
    cap_err  <= err;
    cap_code <= err_code;
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed + k * 37 + k / 3) & 255);
  endfunction

  function automatic logic [7:0] crc_of(input frame_t f);
    logic [7:0] c = 8'hFF;
    for (int k = 0; k < FB - 1; k++) begin
      c = c ^ f[k];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic get_frame(output frame_t f, output int stop_bad, output int de_bad);
    stop_bad = 0;
    de_bad   = 0;
    for (int k = 0; k < FB; k++) begin
      while (tx_o) @(negedge clk);
      repeat (CPB / 2) @(negedge clk);
      if (tx_o) stop_bad++;
      if (!de_o) de_bad++;
      for (int b = 0; b < 8; b++) begin
        repeat (CPB) @(negedge clk);
        f[k][b] = tx_o;
      end
      repeat (CPB) @(negedge clk);
      if (!tx_o) stop_bad++;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit last);
    rx_drv = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      rx_drv = v[b];
      repeat (CPB) @(negedge clk);
    end
    rx_drv = 1'b1;
    if (!last) repeat (CPB) @(negedge clk);
  endtask

  task automatic make_reply(input int seed, input int kind, output frame_t r);
    r[0] = (kind == P_BADDELIM) ? 8'h41 : 8'h40;
    for (int k = 1; k <= PB; k++) r[k] = pat(seed, k);
    r[FB-1] = crc_of(r);
    if (kind == P_BADCRC) r[FB-1] = r[FB-1] ^ 8'h01;
  endtask

  task automatic run_case(input string tag, input int seed, input int p0, input int p1,
                          input int p2, input int n, input bit echo_on,
                          input bit exp_err, input int exp_code);
    frame_t f, r;
    int sb, db, w, quiet_bad;
    int plan [3];
    logic [PB*8-1:0] exp_rsp;
    plan = '{p0, p1, p2};
    echo = echo_on;
    for (int k = 1; k <= PB; k++) req[(k-1)*8 +: 8] = pat(seed, k);
    for (int k = 1; k <= PB; k++) exp_rsp[(k-1)*8 +: 8] = pat(seed ^ 8'h5A, k);
    done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int a = 0; a < n; a++) begin
      get_frame(f, sb, db);
      check(f[0] == 8'h40, {tag, " R2"}, "delimiter", int'(f[0]), 'h40);
      w = 0;
      for (int k = 1; k <= PB; k++) if (f[k] != pat(seed, k)) w++;
      check(w == 0, {tag, " R2"}, "payload bytes wrong", w, 0);
      check(f[FB-1] == crc_of(f), {tag, " R3"}, "crc", int'(f[FB-1]), int'(crc_of(f)));
      check(sb == 0, {tag, " R1"}, "start/stop bits wrong", sb, 0);
      check(db == 0, {tag, " R4"}, "de low during bits", db, 0);
      check(done_cnt == 0, {tag, " R8"}, "done before last attempt", done_cnt, 0);
      if (plan[a] != P_NONE) begin
        repeat (2 * CPB) @(negedge clk);
        make_reply(seed ^ 8'h5A, plan[a], r);
        for (int k = 0; k < FB; k++) send_byte(r[k], k == FB - 1);
      end
    end
    w = 0;
    while (done_cnt == 0 && w < TMO + 40 * CPB * FB) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    check(done_cnt == 1, {tag, " R9"}, "done count", done_cnt, 1);
    check(cap_err == exp_err, {tag, exp_err ? " R9" : " R5"}, "err", int'(cap_err), int'(exp_err));
    check(cap_code == 2'(exp_code), {tag, exp_err ? " R9" : " R5"}, "err_code", int'(cap_code), exp_code);
    if (!exp_err) check(rsp == exp_rsp, {tag, " R5"}, "rsp_payload low word",
                        int'(rsp[31:0]), int'(exp_rsp[31:0]));
    quiet_bad = 0;
    repeat (40 * CPB) begin
      @(negedge clk);
      if (!tx_o || de_o) quiet_bad++;
    end
    check(quiet_bad == 0, {tag, " R8"}, "line activity after done", quiet_bad, 0);
    check(done_cnt == 1, {tag, " R11"}, "done pulses", done_cnt, 1);
    echo = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_err = 0;
    done_cnt = 0;
    cap_err = 1'b0;
    cap_code = 2'd0;
    rst_n = 1'b0;
    start = 1'b0;
    rx_drv = 1'b1;
    echo = 1'b0;
    req = '0;
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R11", "done in reset", int'(done), 0);
    check(de_o == 1'b0, "R11", "de_o in reset", int'(de_o), 0);
    check(tx_o == 1'b1, "R11", "tx_o in reset", int'(tx_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_case("first_try",     8'h11, P_GOOD,     P_GOOD,     P_GOOD,     1, 1'b0, 1'b0, 0);
    run_case("all_timeout R6", 8'h23, P_NONE,    P_NONE,     P_NONE,     3, 1'b0, 1'b1, 1);
    run_case("badcrc_then_ok R7", 8'h35, P_BADCRC, P_GOOD,   P_GOOD,     2, 1'b0, 1'b0, 0);
    run_case("bad_delim R7",  8'h47, P_BADDELIM, P_BADDELIM, P_BADDELIM, 3, 1'b0, 1'b1, 2);
    run_case("third_try",     8'h59, P_NONE,     P_NONE,     P_GOOD,     3, 1'b0, 1'b0, 0);
    run_case("crc_then_tmo",  8'h6B, P_BADCRC,   P_BADCRC,   P_NONE,     3, 1'b0, 1'b1, 1);
    run_case("echo R10",      8'h7D, P_NONE,     P_NONE,     P_NONE,     3, 1'b1, 1'b1, 1);
    run_case("pattern2",      8'hC3, P_GOOD,     P_GOOD,     P_GOOD,     1, 1'b0, 1'b0, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule